// File: doc/BRIEF.md
# Configurable Slice Storage Pair

This block models two storage cells that share one set of slice control lines. Each cell is configured on its own. It can behave as an edge-triggered flip-flop or as a level-sensitive latch. It can take its data from a function-generator result or from a bypass input, and it has its own start-up value. The shared controls are a slice clock, a clock enable, a force toward the start-up value and a force toward the opposite value. Each of these four lines can be inverted on its own, and one shared bit selects whether the two forces act synchronously or asynchronously.

The model is cycle-based. A system clock `clk` samples the slice clock and the other control lines on every rising edge and updates the two cell outputs. Every effect is therefore visible one system clock after the inputs that cause it. A slice clock edge is a change of the effective slice clock from 0 to 1 between two consecutive samples. While `rst_n` is low, the configuration is being loaded and each cell holds its start-up value. The configuration inputs are meant to stay constant while `rst_n` is high.

Top module: `slice_store_pair`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, each `q[i]` takes `cfg_init[i]`, so in the sample after the release of reset `q` equals `cfg_init`.
- R2: Cell i takes its data from `byp_d[i]` when `cfg_byp[i]` is 1 and from `fg_d[i]` when `cfg_byp[i]` is 0.
- R3: When `cfg_latch[i]` is 0 (flip-flop), cell i loads its data only on a sample where the effective slice clock is 1 and was 0 on the previous sample, and only if the effective enable is 1. Otherwise, with no force acting, it holds.
- R4: When `cfg_latch[i]` is 1 (latch), cell i follows its data on every sample where both the effective slice clock and the effective enable are 1. On all other samples, with no force acting, it holds.
- R5: An acting force-to-init drives `q[i]` to `cfg_init[i]`, whatever the enable and the data.
- R6: An acting force-to-opposite, with no force-to-init acting, drives `q[i]` to the inverse of `cfg_init[i]`, whatever the enable and the data.
- R7: When both forces are active on the same sample, force-to-init wins.
- R8: With `cfg_async` 0, a force acts only on a sample where the cell would capture: a slice clock edge for a flip-flop, or an effective clock of 1 for a latch. The enable plays no part in this.
- R9: With `cfg_async` 1, an active force acts on every sample, whatever the slice clock.
- R10: Each control line is XORed with its own inversion bit before use: `cfg_inv` bit 0 for the slice clock, bit 1 for the enable, bit 2 for force-to-init and bit 3 for force-to-opposite. The two cells use the same effective controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low configuration load, synchronous |
| cfg_latch | input | N | Per cell: 1 selects latch, 0 selects flip-flop |
| cfg_byp | input | N | Per cell: 1 selects the bypass data input |
| cfg_init | input | N | Per cell start-up value |
| cfg_async | input | 1 | 1 makes both forces asynchronous |
| cfg_inv | input | 4 | Inversion bits for clock, enable, force-to-init, force-to-opposite |
| fg_d | input | N | Function-generator data, one bit per cell |
| byp_d | input | N | Bypass data, one bit per cell |
| sclk | input | 1 | Shared slice clock |
| sce | input | 1 | Shared clock enable |
| frc_init | input | 1 | Shared force toward the start-up value |
| frc_opp | input | 1 | Shared force toward the opposite value |
| q | output | N | Cell outputs |

## Verification
The bench steps through 32 configurations. The async bit, both storage modes and both data sources are swept across the two cells, and the start-up values and inversion bits are random. Within each configuration the slice clock toggles irregularly, while enable, data and the two forces take random values. A slow clock with long high phases separates latch transparency from edge capture. Cells in different modes under the same controls show whether the controls are shared correctly. Forces that arrive between clock edges separate synchronous from asynchronous action, and occasional overlapping forces test the priority. A behavioural model in the bench predicts both outputs on every sample. Each mismatch names the rule that decided the expected value.

// File: rtl/slice_store_pair.sv
module slice_store_pair #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cfg_latch,
  input  logic [N-1:0] cfg_byp,
  input  logic [N-1:0] cfg_init,
  input  logic         cfg_async,
  input  logic [3:0]   cfg_inv,
  input  logic [N-1:0] fg_d,
  input  logic [N-1:0] byp_d,
  input  logic         sclk,
  input  logic         sce,
  input  logic         frc_init,
  input  logic         frc_opp,
  output logic [N-1:0] q
);

  logic ck, ce, fi, fo, ck_q, rise;
  logic [N-1:0] win, dsel, nxt;

  // R10: per-line inversion, shared by every cell
  assign ck = sclk     ^ cfg_inv[0];
  assign ce = sce      ^ cfg_inv[1];
  assign fi = frc_init ^ cfg_inv[2];
  assign fo = frc_opp  ^ cfg_inv[3];

  always_ff @(posedge clk) ck_q <= ck;
  assign rise = ck & ~ck_q;

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic act;
    assign win[i]  = cfg_latch[i] ? ck : rise;
    assign dsel[i] = cfg_byp[i] ? byp_d[i] : fg_d[i];
    assign act     = cfg_async | win[i];
    always_comb begin
      if (fi && act)             nxt[i] = cfg_init[i];
      else if (fo && act)        nxt[i] = ~cfg_init[i];
      else if (win[i] && ce)     nxt[i] = dsel[i];
      else                       nxt[i] = q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= cfg_init;
    else        q <= nxt;
  end

endmodule

// File: rtl/slice_store_pair_chk.sv
module slice_store_pair_chk #(
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] cfg_latch,
  input logic [N-1:0] cfg_byp,
  input logic [N-1:0] cfg_init,
  input logic         cfg_async,
  input logic [3:0]   cfg_inv,
  input logic [N-1:0] fg_d,
  input logic [N-1:0] byp_d,
  input logic         sclk,
  input logic         sce,
  input logic         frc_init,
  input logic         frc_opp,
  input logic [N-1:0] q
);

  logic c_ck, c_fi, c_fo, c_prev, c_rise;
  assign c_ck = sclk     ^ cfg_inv[0];
  assign c_fi = frc_init ^ cfg_inv[2];
  assign c_fo = frc_opp  ^ cfg_inv[3];
  always_ff @(posedge clk) c_prev <= c_ck;
  assign c_rise = c_ck & ~c_prev;

  AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q == $past(cfg_init)); // R1

  AST_BOTH_FORCE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_async && c_fi && c_fo) |=> q == $past(cfg_init)); // R7

  AST_ASYNC_OPP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_async && !c_fi && c_fo) |=> q == ~$past(cfg_init)); // R6

  AST_FF_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_async && !c_rise) |=> (q & ~cfg_latch) == ($past(q) & ~cfg_latch)); // R8

  AST_LATCH_CLOSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_async && !c_ck) |=> (q & cfg_latch) == ($past(q) & cfg_latch)); // R4

endmodule

bind slice_store_pair slice_store_pair_chk #(.N(N)) u_chk (.*);

// File: tb/tb_slice_store_pair.sv
module tb_slice_store_pair;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;

  logic clk = 0;
  logic rst_n;
  logic [N-1:0] cfg_latch, cfg_byp, cfg_init, fg_d, byp_d, q;
  logic cfg_async, sclk, sce, frc_init, frc_opp;
  logic [3:0] cfg_inv;

  slice_store_pair #(.N(N)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit m [N];
  string mtag [N];
  bit mprev;

  // behavioural reference, evaluated on the inputs present at each edge
  always @(posedge clk) begin
    bit ck, ce, fi, fo, open, act, edge_seen;
    ck = sclk ^ cfg_inv[0];
    ce = sce ^ cfg_inv[1];
    fi = frc_init ^ cfg_inv[2];
    fo = frc_opp ^ cfg_inv[3];
    edge_seen = ck && !mprev;
    for (int e = 0; e < N; e++) begin
      if (!rst_n) begin
        m[e] = cfg_init[e]; mtag[e] = "R1";
      end else begin
        open = cfg_latch[e] ? ck : edge_seen;
        act = cfg_async || open;
        if (fi && act) begin
          m[e] = cfg_init[e];
          mtag[e] = fo ? "R7" : (cfg_async ? "R5 R9" : "R5 R8");
        end else if (fo && act) begin
          m[e] = !cfg_init[e];
          mtag[e] = cfg_async ? "R6 R9" : "R6 R8";
        end else if (open && ce) begin
          m[e] = cfg_byp[e] ? byp_d[e] : fg_d[e];
          mtag[e] = cfg_latch[e] ? "R4 R2" : "R3 R2";
        end else begin
          mtag[e] = cfg_latch[e] ? "R4 hold" : "R3 hold";
        end
      end
    end
    mprev = ck;
  end

  task automatic compare();
    for (int e = 0; e < N; e++) begin
      compared++;
      if (q[e] !== m[e]) begin
        mismatched++;
        $display("FAIL %s%s cell %0d: q=%b expected=%b", mtag[e],
                 (cfg_inv != 0) ? " R10" : "", e, q[e], m[e]);
      end
    end
  endtask

  task automatic randomize_inputs();
    if ($urandom_range(2) == 0) sclk = ~sclk;
    sce      = ($urandom_range(3) != 0);
    frc_init = ($urandom_range(7) == 0) ^ cfg_inv[2];
    frc_opp  = ($urandom_range(7) == 0) ^ cfg_inv[3];
    fg_d     = N'($urandom);
    byp_d    = N'($urandom);
  endtask

  initial begin
    rst_n = 0; sclk = 0; sce = 0; frc_init = 0; frc_opp = 0;
    fg_d = 0; byp_d = 0; cfg_latch = 0; cfg_byp = 0; cfg_init = 0;
    cfg_async = 0; cfg_inv = 0;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      rst_n     = 0;
      cfg_async = c[0];
      cfg_latch = c[2:1];
      cfg_byp   = c[4:3];
      cfg_init  = N'($urandom);
      cfg_inv   = (c < 4) ? 4'd0 : 4'($urandom);
      frc_init  = cfg_inv[2];
      frc_opp   = cfg_inv[3];
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        randomize_inputs();
        frc_init = cfg_inv[2];
        frc_opp  = cfg_inv[3];
      end
      @(negedge clk);
      compare(); // R1 reset state
      rst_n = 1;
      for (int k = 0; k < 150; k++) begin
        @(negedge clk);
        compare();
        randomize_inputs();
      end
    end
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule